// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two integer operands over several clock cycles and returns a product twice their width. It has one adder that is only as wide as an operand. The multiplier operand does not get a register of its own. It is loaded into the low half of a double-width product register. Each cycle, the bit that sits at position 0 of that register decides whether the multiplicand is added into the high half. After that, the whole register moves right by one place, with the adder's carry entering at the top.

A caller asserts `start` for one cycle while the block is idle and supplies both operands and a mode bit at the same time. `busy` stays high while the loop runs. When the product is ready, `done` pulses for one cycle and `product` updates. Unsigned mode runs one iteration for each operand bit.

Signed mode works on the operand magnitudes and runs one iteration fewer, because the sign bit is not processed. If the operand signs differ, the product is negated at the end. When the multiplier is the most negative value, its magnitude bit is the one the shortened loop leaves unprocessed. The finishing stage picks that case out and forms the product by shifting the multiplicand instead.

Top module: `shift_add_mul`

## Requirements
- R1: With `signed_mode` low at start, `product` equals the unsigned product of `op_a` and `op_b`, modulo 2^(2·DATA_W), for every operand pair, including all-ones times all-ones, where the adder's carry must be kept.
- R2: With `signed_mode` high at start, `product` equals the two's-complement product of `op_a` and `op_b`, as a 2·DATA_W-bit two's-complement value. This includes pairs where either operand, or both, is the most negative value.
- R3: A `start` seen at a clock edge while `busy` is low is accepted, and `busy` is high after that edge. `busy` never rises without an accepted start.
- R4: If a start is accepted at edge e, `done` is first high after edge e+DATA_W in unsigned mode and after edge e+DATA_W−1 in signed mode.
- R5: `done` is high for exactly one cycle. It is high exactly in the cycle after `busy` falls, and `busy` is low in that cycle.
- R6: A `start` while `busy` is high is ignored. Its operands and mode do not affect the running operation or its latency.
- R7: `product` changes only in the cycle where `done` is high. Between completions it holds its value, including while a new operation is running.
- R8: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `product` is 0.
- R9: The mode is captured at the accepted start. Changing `signed_mode` during a run does not change that run's result or latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new multiplication; honoured only while idle |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| op_a | input | DATA_W | Multiplicand |
| op_b | input | DATA_W | Multiplier |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `product` has just been updated |
| product | output | 2·DATA_W | Latest completed product, held between completions |

## Verification
The checker tests the handshake timing on every cycle. It counts the run length against the captured mode, checks that `done` lasts one cycle and coincides with the fall of `busy`, checks that `busy` rises only after an accepted start, and checks that `product` stays stable outside the `done` cycle. Whether the arithmetic is right can only be shown by the bench's scenarios. These cover an exhaustive sweep over all operand pairs in both modes on a 5-bit instance, with an ignored start and a flipped mode bit injected into every run, and directed and pseudo-random full-width cases that include carry-heavy and most-negative operands.

// File: rtl/mulsa_pkg.sv
// Package mulsa_pkg
// Shared types for the sequential shift-add multiplier.
package mulsa_pkg;

    // Controller phase: waiting for a request, or iterating.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

endpackage

// File: rtl/mulsa_operand_prep.sv
// Module mulsa_operand_prep
// Turns the raw operands into the unsigned values the loop consumes.
// In signed mode each operand is replaced by its magnitude, and a flag records
// whether the final product must be negated. The magnitude of the most
// negative value is 2^(DATA_W-1), which still fits in DATA_W unsigned bits.
// Assumes: purely combinational, evaluated in the load cycle.
module mulsa_operand_prep #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              signed_mode,
    output logic [DATA_W-1:0] mcand_mag,
    output logic [DATA_W-1:0] mplier_mag,
    output logic              flip_sign
);

    logic neg_a;
    logic neg_b;

    // Pick sign bits only when the operands are two's complement.
    always_comb begin
        neg_a = signed_mode & op_a[DATA_W-1];
        neg_b = signed_mode & op_b[DATA_W-1];
    end

    // Form magnitudes and the result-sign flag.
    always_comb begin
        mcand_mag  = neg_a ? (~op_a + 1'b1) : op_a;
        mplier_mag = neg_b ? (~op_b + 1'b1) : op_b;
        flip_sign  = neg_a ^ neg_b;
    end

endmodule

// File: rtl/mulsa_step.sv
// Module mulsa_step
// One loop iteration in a single cycle. If bit 0 of the product register is
// set, the multiplicand is added to the upper half. The adder's carry and sum
// then become the new upper bits, as the whole register moves right by one.
// Assumes: the multiplier bits still unused occupy the low end of prod_q.
module mulsa_step #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] prod_q,
    input  logic [DATA_W-1:0]   mcand,
    output logic [2*DATA_W-1:0] prod_d
);

    logic [DATA_W:0]   addend;
    logic [DATA_W:0]   upper_sum;

    // Conditional add of the multiplicand into the upper half, keeping the carry.
    always_comb begin
        addend    = prod_q[0] ? {1'b0, mcand} : '0;
        upper_sum = {1'b0, prod_q[2*DATA_W-1:DATA_W]} + addend;
    end

    // Right shift by one: carry enters bit 2*DATA_W-1, bit 0 is consumed.
    always_comb begin
        prod_d = {upper_sum, prod_q[DATA_W-1:1]};
    end

endmodule

// File: rtl/mulsa_finish.sv
// Module mulsa_finish
// Produces the final result from the register value after the last step.
// Unsigned runs use that value as it stands. Signed runs stop one step early,
// so the magnitude product lies one position to the left of the final place.
// Bit 0 then holds the multiplier magnitude's top bit, which is set only for
// the most negative multiplier. In that case every lower bit was zero, and
// the magnitude product is the multiplicand shifted left by DATA_W-1.
// Assumes: flip_sign is never set on unsigned runs.
module mulsa_finish #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] prod_last,
    input  logic [DATA_W-1:0]   mcand,
    input  logic                run_signed,
    input  logic                flip_sign,
    output logic [2*DATA_W-1:0] result
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] mcand_wide;
    logic [PROD_W-1:0] signed_mag;
    logic [PROD_W-1:0] magnitude;

    // Recover the signed-mode magnitude product.
    always_comb begin
        mcand_wide = {{DATA_W{1'b0}}, mcand};
        signed_mag = prod_last[0] ? (mcand_wide << (DATA_W - 1)) : (prod_last >> 1);
    end

    // Select by mode and apply the sign.
    always_comb begin
        magnitude = run_signed ? signed_mag : prod_last;
        result    = flip_sign ? (~magnitude + 1'b1) : magnitude;
    end

endmodule

// File: rtl/mulsa_ctrl.sv
// Module mulsa_ctrl
// Sequences one multiplication. It accepts a start only while idle, captures
// the mode, loads the iteration count (DATA_W for unsigned, DATA_W-1 for
// signed) and counts down one per cycle. The done pulse is registered so
// that it appears together with the fall of busy.
// Assumes: DATA_W >= 2; synchronous active-low reset.
module mulsa_ctrl
    import mulsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic signed_mode,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic last,
    output logic run_signed
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    mul_state_e        state_q;
    logic [CNT_W-1:0]  iter_q;
    logic              sgn_q;
    logic              done_q;

    // Decode the per-cycle actions from the phase and the counter.
    always_comb begin
        load = start && (state_q == ST_IDLE);
        step = (state_q == ST_RUN);
        last = step && (iter_q == CNT_W'(1));
    end

    // Advance phase, counter, captured mode and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            sgn_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                state_q <= ST_RUN;
                sgn_q   <= signed_mode;
                iter_q  <= signed_mode ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
            end else if (step) begin
                iter_q <= iter_q - 1'b1;
                if (last) begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    // Present the registered state.
    always_comb begin
        busy       = (state_q == ST_RUN);
        done       = done_q;
        run_signed = sgn_q;
    end

endmodule

// File: rtl/shift_add_mul.sv
// Module shift_add_mul
// Multi-cycle multiplier with a single DATA_W-bit adder. The multiplier shares
// a 2*DATA_W-bit register with the growing product. One cycle loads it, then
// one add-and-shift iteration runs per cycle. The result register updates
// only when a run completes.
// Assumes: start is honoured only while busy is low; synchronous active-low reset.
module shift_add_mul #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                signed_mode,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    output logic                busy,
    output logic                done,
    output logic [2*DATA_W-1:0] product
);

    localparam int PROD_W = 2 * DATA_W;

    logic              load;
    logic              step;
    logic              last;
    logic              run_signed;
    logic [DATA_W-1:0] mcand_mag;
    logic [DATA_W-1:0] mplier_mag;
    logic              flip_now;

    logic [PROD_W-1:0] prod_q;
    logic [PROD_W-1:0] prod_d;
    logic [DATA_W-1:0] mcand_q;
    logic              flip_q;
    logic [PROD_W-1:0] final_val;
    logic [PROD_W-1:0] result_q;

    mulsa_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .busy        (busy),
        .done        (done),
        .load        (load),
        .step        (step),
        .last        (last),
        .run_signed  (run_signed)
    );

    mulsa_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .op_a        (op_a),
        .op_b        (op_b),
        .signed_mode (signed_mode),
        .mcand_mag   (mcand_mag),
        .mplier_mag  (mplier_mag),
        .flip_sign   (flip_now)
    );

    mulsa_step #(.DATA_W(DATA_W)) u_step (
        .prod_q (prod_q),
        .mcand  (mcand_q),
        .prod_d (prod_d)
    );

    mulsa_finish #(.DATA_W(DATA_W)) u_finish (
        .prod_last  (prod_d),
        .mcand      (mcand_q),
        .run_signed (run_signed),
        .flip_sign  (flip_q),
        .result     (final_val)
    );

    // Load operands on an accepted start, iterate while running, capture on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q   <= '0;
            mcand_q  <= '0;
            flip_q   <= 1'b0;
            result_q <= '0;
        end else if (load) begin
            prod_q  <= {{DATA_W{1'b0}}, mplier_mag};
            mcand_q <= mcand_mag;
            flip_q  <= flip_now;
        end else if (step) begin
            prod_q <= prod_d;
            if (last) begin
                result_q <= final_val;
            end
        end
    end

    // Drive the held result.
    always_comb begin
        product = result_q;
    end

endmodule

// File: rtl/mulsa_checker.sv
// Module mulsa_checker
// Cycle-level protocol checks for shift_add_mul, attached by bind. It keeps
// its own count of cycles since each accepted start and its own copy of the
// captured mode, then compares the done timing against them.
// Assumes: rst_n is low from time zero until the first clock edges.
module mulsa_checker #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                signed_mode,
    input logic                busy,
    input logic                done,
    input logic [2*DATA_W-1:0] product
);

    localparam int CNT_W = $clog2(DATA_W + 1) + 1;

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] exp_len;

    // Track cycles since the accepted start and the expected run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            exp_len <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            exp_len <= signed_mode ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_no_spurious_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6 and R9: an ignored start or a mode change must not alter the length.
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == exp_len));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_fall_gives_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

endmodule

bind shift_add_mul mulsa_checker #(.DATA_W(DATA_W)) u_mulsa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .busy        (busy),
    .done        (done),
    .product     (product)
);

// File: tb/shift_add_mul_bench.sv
// Bench for shift_add_mul: exhaustive sweep on a 5-bit instance, directed and
// pseudo-random cases on a 32-bit instance. Inputs change and outputs are
// sampled on falling edges.
module shift_add_mul_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 5;
    localparam int LW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic            s_start = 1'b0, s_sgn = 1'b0, s_busy, s_done;
    logic [SW-1:0]   s_a = '0, s_b = '0;
    logic [2*SW-1:0] s_res;

    logic            l_start = 1'b0, l_sgn = 1'b0, l_busy, l_done;
    logic [LW-1:0]   l_a = '0, l_b = '0;
    logic [2*LW-1:0] l_res;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] s_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_add_mul #(.DATA_W(SW)) u_shift_add_mul (
        .clk(clk), .rst_n(rst_n), .start(s_start), .signed_mode(s_sgn),
        .op_a(s_a), .op_b(s_b), .busy(s_busy), .done(s_done), .product(s_res)
    );

    shift_add_mul #(.DATA_W(LW)) u_shift_add_mul_wide (
        .clk(clk), .rst_n(rst_n), .start(l_start), .signed_mode(l_sgn),
        .op_a(l_a), .op_b(l_b), .busy(l_busy), .done(l_done), .product(l_res)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference product for width w, computed arithmetically.
    function automatic logic [63:0] model(input int w, input logic [63:0] a, input logic [63:0] b, input bit sgn);
        logic [63:0] mask;
        longint sa, sb;
        mask = (w >= 32) ? '1 : ((64'd1 << (2*w)) - 1);
        if (sgn) begin
            sa = a[w-1] ? (longint'(a) - (longint'(1) << w)) : longint'(a);
            sb = b[w-1] ? (longint'(b) - (longint'(1) << w)) : longint'(b);
            return 64'(sa * sb) & mask;
        end
        return (a * b) & mask;
    endfunction

    // One small-instance run; optionally pokes a start and flips the mode mid-run.
    task automatic small_run(input int a, input int b, input bit sgn, input bit poke);
        int k;
        int len;
        logic [63:0] exp;
        exp = model(SW, 64'(a), 64'(b), sgn);
        len = sgn ? SW - 1 : SW;
        @(negedge clk);
        s_a = a[SW-1:0]; s_b = b[SW-1:0]; s_sgn = sgn; s_start = 1'b1;
        @(negedge clk);
        k = 1;
        s_start = 1'b0;
        check(s_busy === 1'b1, "R3 busy after start", 64'(s_busy), 64'd1);
        check(s_res === s_prev[2*SW-1:0], "R7 result held during run", 64'(s_res), s_prev);
        if (poke) begin
            s_start = 1'b1; s_a = ~s_a; s_b = s_b + 1'b1; s_sgn = ~sgn;
        end
        while (s_done !== 1'b1 && k < 100) begin
            @(negedge clk);
            k++;
            s_start = 1'b0;
        end
        // R6 and R9: the ignored start and the mode flip leave latency and value intact.
        check(k == len + 1, "R4 latency", 64'(k), 64'(len + 1));
        check(s_res === exp[2*SW-1:0], sgn ? "R2 signed product" : "R1 unsigned product", 64'(s_res), exp);
        @(negedge clk);
        check(s_done === 1'b0 && s_busy === 1'b0, "R5 done single cycle", 64'({s_done, s_busy}), 64'd0);
        check(s_res === exp[2*SW-1:0], "R7 result held after done", 64'(s_res), exp);
        s_prev = exp;
    endtask

    // One wide-instance run.
    task automatic wide_run(input logic [LW-1:0] a, input logic [LW-1:0] b, input bit sgn);
        int k;
        int len;
        logic [63:0] exp;
        exp = model(LW, 64'(a), 64'(b), sgn);
        len = sgn ? LW - 1 : LW;
        @(negedge clk);
        l_a = a; l_b = b; l_sgn = sgn; l_start = 1'b1;
        @(negedge clk);
        k = 1;
        l_start = 1'b0;
        while (l_done !== 1'b1 && k < 200) begin
            @(negedge clk);
            k++;
        end
        check(k == len + 1, "R4 wide latency", 64'(k), 64'(len + 1));
        check(l_res === exp, sgn ? "R2 wide signed product" : "R1 wide unsigned product", l_res, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state on both instances.
        check(s_busy === 1'b0 && s_done === 1'b0, "R8 reset flags", 64'({s_busy, s_done}), 64'd0);
        check(s_res === '0, "R8 reset product", 64'(s_res), 64'd0);
        check(l_busy === 1'b0 && l_done === 1'b0 && l_res === '0, "R8 wide reset", l_res, 64'd0);

        // R1, R2: exhaustive sweep in both modes with mid-run interference.
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < (1 << SW); a++) begin
                for (int b = 0; b < (1 << SW); b++) begin
                    small_run(a, b, m[0], 1'b1);
                end
            end
        end

        // R1: carry-heavy and boundary cases at full width.
        wide_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        wide_run(32'h8000_0000, 32'h0000_0002, 1'b0);
        wide_run(32'h0000_0000, 32'hDEAD_BEEF, 1'b0);
        // R2: most negative operands and mixed signs.
        wide_run(32'h8000_0000, 32'h8000_0000, 1'b1);
        wide_run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        wide_run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        wide_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        wide_run(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] x;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr * 32'h9E37_79B9;
            wide_run(lfsr, x, i[0]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule